// File: doc/BRIEF.md
# Microframe Interrupt Pacer

This block sits between the event sources of a USB host/device controller and the interrupt line it presents to the processor. Raw one-cycle event pulses are captured into sticky status bits. Software clears a status bit by writing 1 to it. A mask register selects which status bits may raise the interrupt. An 8-bit threshold code limits how often the interrupt may be issued. The limit is measured in microframes, which arrive as a single-cycle tick input.

The block also holds an async-advance doorbell. In host mode, with the asynchronous schedule running, software sets the doorbell. When the controller reports that cached schedule state has been evicted (the `evict_done` pulse), the block raises a dedicated status bit. It then clears the doorbell on its own one cycle later. That status bit is paced by the threshold in the same way as every other event.

Software reaches the block through a plain strobe bus with a registered read port. There are three registers: control (address 0), status (address 1) and mask (address 2).

Top module: `uframe_irq_pacer`

## Requirements
- R1: After reset `irq` is 0 and the control, status and mask registers all read 0. The microframe counter starts saturated, so no spacing is enforced before the first interrupt.
- R2: A pulse on `ev_in[i]` sets status bit i, and that bit stays set until software writes 1 to it at address 1. If a set and a clear meet in the same cycle, the set wins.
- R3: `irq` is raised only by a status bit whose mask bit (address 2, same bit position) is 1. A pending bit with mask 0 never raises `irq`.
- R4: With threshold code 0x00, an enabled status bit latched at one clock edge drives `irq` high at the next edge.
- R5: With a nonzero code, the interval is the value of the code's highest set bit (1, 2, 4, ... 64 microframes), so illegal codes fall to the nearest lower legal value, and codes of 0x80 and above give 64. `irq` rises only after that many ticks have been counted since the last issue. Issuing the interrupt clears the tick counter, and the counter saturates at 64.
- R6: Once raised, `irq` stays high while any enabled status bit is pending. It falls one cycle after the last one is cleared.
- R7: The control register holds the threshold code in bits [7:0] and the doorbell in bit 8. Writing 1 to bit 8 sets the doorbell only when `host_mode` and `async_active` are both 1; otherwise the write is ignored. Writing 0 to bit 8 never clears it.
- R8: An `evict_done` pulse while the doorbell is set sets status bit 4 (async advance) at that edge. The doorbell reads 0 from the following cycle on, and never clears before the status bit is set.
- R9: The async-advance status raises `irq` only at a threshold boundary, exactly like the event bits.
- R10: `rdata` shows the selected register one cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uf_tick | input | 1 | One-cycle microframe pulse |
| ev_in | input | NUM_EV | Raw event pulses |
| host_mode | input | 1 | Controller is in host mode |
| async_active | input | 1 | Asynchronous schedule is running |
| evict_done | input | 1 | Cached schedule state has been evicted |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Paced interrupt request |

## Verification
The embedded assertions check four rules on every cycle:
- status bits neither appear nor vanish without a set or a clear;
- `irq` only rises when the gate was open, and only while an enabled bit is pending;
- the tick counter never passes its ceiling;
- the doorbell only rises in host mode with the schedule active, and only falls after the async-advance status is set.

Several behaviours can only be shown by the directed scenarios:
- the exact tick count before `irq` rises for a given code, including an illegal code;
- one-cycle latency at code 0x00;
- the set-over-clear collision;
- doorbell writes being ignored in device mode, as seen through the control register.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/uirq_thr_decode.sv
module uirq_thr_decode #(
  parameter int CODE_W  = 8,
  parameter int MAX_LOG = 6,
  localparam int IV_W   = MAX_LOG + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic              immediate,
  output logic [IV_W-1:0]   interval
);
  // highest set bit wins; bits above MAX_LOG clamp to the top interval
  always_comb begin
    immediate = (code == '0);
    interval  = '0;
    for (int b = 0; b < CODE_W; b++) begin
      if (code[b]) begin
        if (b > MAX_LOG) interval = IV_W'(1) << MAX_LOG;
        else             interval = IV_W'(1) << b;
      end
    end
  end
endmodule

// File: rtl/uirq_pace_ctr.sv
module uirq_pace_ctr #(
  parameter int MAX_LOG = 6,
  localparam int IV_W   = MAX_LOG + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            any_pend,
  input  logic            immediate,
  input  logic [IV_W-1:0] interval,
  output logic            irq
);
  localparam logic [IV_W-1:0] CNT_MAX = IV_W'(1) << MAX_LOG;

  logic [IV_W-1:0] cnt_q;
  logic            irq_q;
  logic            gate_open, irq_d, issue;

  assign gate_open = immediate || (cnt_q >= interval);
  assign irq_d     = any_pend && (irq_q || gate_open);
  assign issue     = irq_d && !irq_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_MAX;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (issue)                       cnt_q <= '0;
      else if (tick && cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(immediate || (cnt_q >= interval)));
  // R3
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(any_pend));
  // R5
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/uirq_status_bank.sv
module uirq_status_bank #(
  parameter int NSTAT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTAT-1:0] set_ev,
  input  logic [NSTAT-1:0] clr,
  output logic [NSTAT-1:0] stat
);
  logic [NSTAT-1:0] stat_q;
  assign stat = stat_q;

  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= (stat_q[i] && !clr[i]) || set_ev[i];
    end
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !clr[i]) |=> stat_q[i]);
    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!stat_q[i] && !set_ev[i]) |=> !stat_q[i]);
  end
endmodule

// File: rtl/uirq_doorbell.sv
module uirq_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  input  logic host_mode,
  input  logic async_active,
  input  logic evict_done,
  input  logic adv_stat,
  output logic bell,
  output logic adv_set
);
  logic bell_q, done_q, ring_ok;

  assign ring_ok = ring && host_mode && async_active && !bell_q;
  assign adv_set = bell_q && !done_q && evict_done;
  assign bell    = bell_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bell_q <= 1'b0;
      done_q <= 1'b0;
    end else if (done_q) begin
      bell_q <= 1'b0;
      done_q <= 1'b0;
    end else if (adv_set) begin
      done_q <= 1'b1;
    end else if (ring_ok) begin
      bell_q <= 1'b1;
    end
  end

  // R7
  ring_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bell_q) |-> $past(host_mode && async_active));
  // R8
  clear_after_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bell_q) |-> $past(adv_stat));
endmodule

// File: rtl/uframe_irq_pacer.sv
module uframe_irq_pacer
  import uirq_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int CODE_W  = 8,
  parameter int MAX_LOG = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uf_tick,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              host_mode,
  input  logic              async_active,
  input  logic              evict_done,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NSTAT  = NUM_EV + 1;
  localparam int ADV    = NUM_EV;
  localparam int BELL_B = CODE_W;
  localparam int IV_W   = MAX_LOG + 1;

  logic [CODE_W-1:0] thr_q;
  logic [NSTAT-1:0]  mask_q, stat, clr, set_ev;
  logic [DATA_W-1:0] rdata_q;
  logic              bell, adv_set, ring, wr_ctrl, immediate;
  logic [IV_W-1:0]   interval;

  assign wr_ctrl = wr_en && (addr == SEL_CTRL);
  assign ring    = wr_ctrl && wdata[BELL_B];
  assign clr     = (wr_en && addr == SEL_STAT) ? wdata[NSTAT-1:0] : '0;
  assign set_ev  = {adv_set, ev_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == SEL_CTRL) thr_q  <= wdata[CODE_W-1:0];
      if (addr == SEL_MASK) mask_q <= wdata[NSTAT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en) begin
      case (addr)
        SEL_CTRL: rdata_q <= DATA_W'({bell, thr_q});
        SEL_STAT: rdata_q <= DATA_W'(stat);
        SEL_MASK: rdata_q <= DATA_W'(mask_q);
        default:  rdata_q <= '0;
      endcase
    end
  end
  assign rdata = rdata_q;

  uirq_thr_decode #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_dec (
    .code(thr_q), .immediate(immediate), .interval(interval));

  uirq_status_bank #(.NSTAT(NSTAT)) u_stat (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr(clr), .stat(stat));

  uirq_doorbell u_bell (
    .clk(clk), .rst(rst), .ring(ring), .host_mode(host_mode),
    .async_active(async_active), .evict_done(evict_done),
    .adv_stat(stat[ADV]), .bell(bell), .adv_set(adv_set));

  uirq_pace_ctr #(.MAX_LOG(MAX_LOG)) u_pace (
    .clk(clk), .rst(rst), .tick(uf_tick), .any_pend(|(stat & mask_q)),
    .immediate(immediate), .interval(interval), .irq(irq));

  // R10
  rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata_q));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && |(stat & mask_q)) |=> irq);
endmodule

// File: tb/uframe_irq_pacer_test.sv
module uframe_irq_pacer_test;
  logic        clk = 0, rst = 1, uf_tick = 0, host_mode = 0, async_active = 0;
  logic        evict_done = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  ev_in = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rd;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uframe_irq_pacer uut (.clk(clk), .rst(rst), .uf_tick(uf_tick), .ev_in(ev_in),
    .host_mode(host_mode), .async_active(async_active), .evict_done(evict_done),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic pulse_ev(int i);
    ev_in[i] = 1; @(posedge clk); @(negedge clk); ev_in[i] = 0;
  endtask

  task automatic tick;
    uf_tick = 1; @(posedge clk); @(negedge clk); uf_tick = 0;
  endtask

  task automatic evict;
    evict_done = 1; @(posedge clk); @(negedge clk); evict_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    rdreg(0, rd); chk("R1 ctrl", rd, 0);
    rdreg(1, rd); chk("R1 status", rd, 0);
    rdreg(2, rd); chk("R10/R1 mask", rd, 0);
  endtask

  task automatic t_immediate;
    wr(2, 32'h1); wr(0, 32'h0);
    pulse_ev(0);
    chk("R4 not same cycle", irq, 0);
    step(1); chk("R4 next cycle", irq, 1);
    wr(1, 32'h1); chk("R6 held through clear edge", irq, 1);
    step(1); chk("R6 drop", irq, 0);
  endtask

  task automatic t_masked;
    pulse_ev(1); step(3);
    chk("R3 masked no irq", irq, 0);
    rdreg(1, rd); chk("R2 sticky", rd, 32'h2);
    wr(1, 32'h2); rdreg(1, rd); chk("R2 w1c", rd, 0);
  endtask

  task automatic t_paced(logic [31:0] code, int n, string tag);
    wr(0, code);
    pulse_ev(0);
    for (int i = 0; i < n - 1; i++) tick;
    step(3); chk({tag, " early"}, irq, 0);
    tick; step(1); chk({tag, " on time"}, irq, 1);
    wr(1, 32'h1); step(1);
  endtask

  task automatic t_bell_host;
    host_mode = 1; async_active = 1;
    wr(2, 32'h10); wr(0, 32'h100);
    rdreg(0, rd); chk("R7 bell set", rd, 32'h100);
    evict; step(1);
    chk("R8 adv irq", irq, 1);
    rdreg(0, rd); chk("R8 bell self-clear", rd, 0);
    rdreg(1, rd); chk("R8 adv status", rd, 32'h10);
    wr(1, 32'h10); step(1);
  endtask

  task automatic t_bell_ignored;
    host_mode = 0; async_active = 1;
    wr(0, 32'h100); rdreg(0, rd); chk("R7 device mode ignored", rd, 0);
    evict; step(2);
    rdreg(1, rd); chk("R7 no adv status", rd, 0);
    host_mode = 1; async_active = 0;
    wr(0, 32'h100); rdreg(0, rd); chk("R7 inactive ignored", rd, 0);
    async_active = 1;
  endtask

  task automatic t_bell_paced;
    wr(0, 32'h102);
    evict;
    step(2); chk("R9 adv waits", irq, 0);
    tick; step(2); chk("R9 still waits", irq, 0);
    tick; step(1); chk("R9 at boundary", irq, 1);
    wr(1, 32'h10); step(1);
  endtask

  task automatic t_collide;
    wr(2, 32'h0);
    ev_in[2] = 1; addr = 1; wdata = 32'h4; wr_en = 1;
    @(posedge clk); @(negedge clk);
    ev_in[2] = 0; wr_en = 0;
    rdreg(1, rd); chk("R2 set beats clear", rd, 32'h4);
    wr(1, 32'h4); rdreg(1, rd); chk("R2 cleared", rd, 0);
  endtask

  initial begin
    step(4); rst = 0; step(1);
    t_reset;
    t_immediate;
    t_masked;
    t_paced(32'h04, 4, "R5 code4");
    t_paced(32'h05, 4, "R5 illegal code");
    t_bell_host;
    t_bell_ignored;
    t_bell_paced;
    t_collide;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule